// File: doc/BRIEF.md
# Test Access Port Controller with Test-Mode Decode

This block is the test access port of a chip: the IEEE 1149.1 state machine, a 4-bit instruction register with its decoder, a 1-bit bypass register and an identification register. It runs entirely on the test clock. It also publishes its 16-state controller position as a 4-bit code, so that other test state machines can follow it. Shift, capture and update strobes for the instruction path and the data path go out to the scan chains. Those chains live outside the block. The boundary chain and the internal chain each return a single serial output into the TDO multiplexer.

The instruction register selects one of nine block-test modes or none. It also selects which data path sits between TDI and TDO: bypass, identification, boundary chain or internal chain. Both selections are held in registers that load only while the controller is in Update-IR, or when it returns to Test-Logic-Reset. A new opcode therefore never reaches the mode lines while it is still being shifted in.

Top module: `tap_mode_ctrl`

## Requirements
- R1: While trst_n is low, tap_state is 4'hF at once, with no TCK edge needed. test_mode is all zero, path_sel is 2'b01 (identification) and tdo_en is 0.
- R2: The state codes are Test-Logic-Reset F, Run-Test/Idle C, Select-DR 7, Capture-DR 6, Shift-DR 2, Exit1-DR 1, Pause-DR 3, Exit2-DR 0, Update-DR 5, Select-IR 4, Capture-IR E, Shift-IR A, Exit1-IR 9, Pause-IR B, Exit2-IR 8 and Update-IR D. Transitions follow the 1149.1 state diagram on each rising TCK edge.
- R3: Five rising edges with tms high reach state F from any state. The rising edge taken in state F reloads the identification instruction, so that path_sel becomes 01 and test_mode becomes 0.
- R4: Each strobe is high in exactly one state: ir_capture in E, ir_shift in A, ir_update in D, dr_capture in 6, dr_shift in 2, dr_update in 5. At most one strobe is high at a time.
- R5: Capture-IR loads 0000 into the instruction shift register. Shift-IR moves TDI in at the MSB and sends the LSB out first.
- R6: test_mode and path_sel change only on a rising edge taken in Update-IR or Test-Logic-Reset. They stay stable while an opcode is being shifted.
- R7: test_mode bit by opcode: bit0 0000, bit1 0001, bit2 0010, bit3 0011, bit4 0100, bit5 0111, bit6 1000, bit7 1001, bit8 1101. All other opcodes give all zero. At most one bit is set.
- R8: path_sel is 00 (bypass), 01 (identification), 10 (boundary) or 11 (internal). Opcode 1110 selects 01. Opcode 0010 selects 11. Opcodes 0000, 0001, 0111, 1000 and 1001 select 10. Every other opcode selects 00.
- R9: On the bypass path, Capture-DR loads 0, and each bit shifted in appears on TDO one shift later.
- R10: On the identification path, Capture-DR loads the parameter ID_VALUE, which then shifts out LSB first.
- R11: TDO and tdo_en update on the falling TCK edge. tdo_en is high exactly for the falling edges spent in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| int_so | input | 1 | Serial output of the external internal-scan chain |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_en | output | 1 | Output enable for tdo |
| tap_state | output | 4 | Current controller state code |
| ir_capture | output | 1 | Instruction capture strobe |
| ir_shift | output | 1 | Instruction shift strobe |
| ir_update | output | 1 | Instruction update strobe |
| dr_capture | output | 1 | Data capture strobe |
| dr_shift | output | 1 | Data shift strobe |
| dr_update | output | 1 | Data update strobe |
| path_sel | output | 2 | Selected data path |
| test_mode | output | 9 | Latched block-test mode lines |

## Verification
The controller state appears directly on tap_state. A wrong transition or a wrong code is therefore visible one TCK edge after the tms value that caused it. A faulty instruction decode or a faulty holding register shows up on test_mode and path_sel on the edge that leaves Update-IR. If those lines move while Shift-IR is still in progress, the fault shows before the update. A corrupt bypass or identification register, or a wrong path multiplexer, appears on tdo at the first falling edge spent in Shift-DR. The bench watches every falling edge with tdo_en high against a queue of expected bits, so a stray or a missing shift cycle is caught as well.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  localparam int IR_W   = 4;
  localparam int MODE_W = 9;

  // State codes; other state machines decode these values.
  typedef enum logic [3:0] {
    ST_EX2_DR   = 4'h0,
    ST_EX1_DR   = 4'h1,
    ST_SHIFT_DR = 4'h2,
    ST_PAUSE_DR = 4'h3,
    ST_SEL_IR   = 4'h4,
    ST_UPD_DR   = 4'h5,
    ST_CAP_DR   = 4'h6,
    ST_SEL_DR   = 4'h7,
    ST_EX2_IR   = 4'h8,
    ST_EX1_IR   = 4'h9,
    ST_SHIFT_IR = 4'hA,
    ST_PAUSE_IR = 4'hB,
    ST_IDLE     = 4'hC,
    ST_UPD_IR   = 4'hD,
    ST_CAP_IR   = 4'hE,
    ST_RESET    = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'b00,
    PATH_ID  = 2'b01,
    PATH_BND = 2'b10,
    PATH_INT = 2'b11
  } path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_BLK1    = 4'b0010;
  localparam logic [IR_W-1:0] OP_BLK2    = 4'b0011;
  localparam logic [IR_W-1:0] OP_BLK3    = 4'b0100;
  localparam logic [IR_W-1:0] OP_INTEST  = 4'b0111;
  localparam logic [IR_W-1:0] OP_BLK2_BS = 4'b1000;
  localparam logic [IR_W-1:0] OP_BLK3_BS = 4'b1001;
  localparam logic [IR_W-1:0] OP_ZMODE   = 4'b1101;
  localparam logic [IR_W-1:0] OP_IDENT   = 4'b1110;

  function automatic logic [MODE_W-1:0] mode_of(input logic [IR_W-1:0] op);
    logic [MODE_W-1:0] m;
    m = '0;
    case (op)
      OP_EXTEST:  m[0] = 1'b1;
      OP_SAMPLE:  m[1] = 1'b1;
      OP_BLK1:    m[2] = 1'b1;
      OP_BLK2:    m[3] = 1'b1;
      OP_BLK3:    m[4] = 1'b1;
      OP_INTEST:  m[5] = 1'b1;
      OP_BLK2_BS: m[6] = 1'b1;
      OP_BLK3_BS: m[7] = 1'b1;
      OP_ZMODE:   m[8] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic path_e path_of(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE, OP_INTEST,
      OP_BLK2_BS, OP_BLK3_BS: return PATH_BND;
      OP_BLK1:                return PATH_INT;
      OP_IDENT:               return PATH_ID;
      default:                return PATH_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_nxt;

  always_comb begin
    case (state)
      ST_RESET:    state_nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   state_nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR: state_nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_EX1_DR:   state_nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_nxt = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   state_nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   state_nxt = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   state_nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR: state_nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_EX1_IR:   state_nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_nxt = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   state_nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
      default:     state_nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic              tdi,
  output logic              ir_so,
  output logic [MODE_W-1:0] test_mode,
  output path_e             path_sel
);

  logic [IR_W-1:0]   ir_sr;
  logic [IR_W-1:0]   ir_sr_d;
  logic              ir_sr_en;
  logic              hold_en;
  logic [IR_W-1:0]   hold_op;

  // Instruction shift stage: capture value tied low.
  always_comb begin
    ir_sr_en = (state == ST_CAP_IR) || (state == ST_SHIFT_IR);
    ir_sr_d  = (state == ST_CAP_IR) ? '0 : {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        ir_sr <= '0;
    else if (ir_sr_en) ir_sr <= ir_sr_d;
  end

  assign ir_so = ir_sr[0];

  // Holding stage: decoded lines load only in Update-IR or reset state.
  always_comb begin
    hold_en = (state == ST_UPD_IR) || (state == ST_RESET);
    hold_op = (state == ST_RESET) ? OP_IDENT : ir_sr;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      test_mode <= '0;
      path_sel  <= PATH_ID;
    end else if (hold_en) begin
      test_mode <= mode_of(hold_op);
      path_sel  <= path_of(hold_op);
    end
  end

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0B5A_1C3D
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  path_e      path_sel,
  input  logic       tdi,
  input  logic       ir_so,
  input  logic       bnd_so,
  input  logic       int_so,
  output logic       tdo,
  output logic       tdo_en
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            cap_dr, shf_dr;
  logic            byp_en, id_en;
  logic            byp_d;
  logic [ID_W-1:0] id_d;
  logic            dr_so, tdo_d, shift_any;

  always_comb begin
    cap_dr = (state == ST_CAP_DR);
    shf_dr = (state == ST_SHIFT_DR);
    byp_en = (path_sel == PATH_BYP) && (cap_dr || shf_dr);
    id_en  = (path_sel == PATH_ID)  && (cap_dr || shf_dr);
    byp_d  = cap_dr ? 1'b0 : tdi;
    id_d   = cap_dr ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  always_comb begin
    case (path_sel)
      PATH_BYP: dr_so = byp_q;
      PATH_ID:  dr_so = id_q[0];
      PATH_BND: dr_so = bnd_so;
      default:  dr_so = int_so;
    endcase
    shift_any = (state == ST_SHIFT_DR) || (state == ST_SHIFT_IR);
    tdo_d     = (state == ST_SHIFT_IR) ? ir_so : dr_so;
  end

  // Output stage on the falling edge.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_any;
      if (shift_any) tdo <= tdo_d;
    end
  end

endmodule

// File: rtl/tap_mode_ctrl.sv
`timescale 1ns/1ps
module tap_mode_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE    = 32'h0B5A_1C3D,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic              bnd_so,
  input  logic              int_so,
  output logic              tdo,
  output logic              tdo_en,
  output logic [3:0]        tap_state,
  output logic              ir_capture,
  output logic              ir_shift,
  output logic              ir_update,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic [1:0]        path_sel,
  output logic [MODE_W-1:0] test_mode
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;
  tap_state_e             state;
  path_e                  path_q;
  logic                   ir_so;

  // Reset asserts at once, releases on TCK.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n_s),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck       (tck),
    .rst_n     (rst_n_s),
    .state     (state),
    .tdi       (tdi),
    .ir_so     (ir_so),
    .test_mode (test_mode),
    .path_sel  (path_q)
  );

  tap_dr #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck      (tck),
    .rst_n    (rst_n_s),
    .state    (state),
    .path_sel (path_q),
    .tdi      (tdi),
    .ir_so    (ir_so),
    .bnd_so   (bnd_so),
    .int_so   (int_so),
    .tdo      (tdo),
    .tdo_en   (tdo_en)
  );

  always_comb begin
    tap_state  = state;
    path_sel   = path_q;
    ir_capture = (state == ST_CAP_IR);
    ir_shift   = (state == ST_SHIFT_IR);
    ir_update  = (state == ST_UPD_IR);
    dr_capture = (state == ST_CAP_DR);
    dr_shift   = (state == ST_SHIFT_DR);
    dr_update  = (state == ST_UPD_DR);
  end

endmodule

// File: rtl/tap_mode_ctrl_chk.sv
`timescale 1ns/1ps
module tap_mode_ctrl_chk (
  input logic       tck,
  input logic       rst_n_s,
  input logic       tms,
  input logic [3:0] tap_state,
  input logic       ir_capture,
  input logic       ir_shift,
  input logic       ir_update,
  input logic       dr_capture,
  input logic       dr_shift,
  input logic       dr_update,
  input logic [1:0] path_sel,
  input logic [8:0] test_mode,
  input logic       tdo_en
);

  assert_reset_exit_R2: assert property (@(posedge tck) disable iff (!rst_n_s)
    (tap_state == 4'hF && !tms) |=> (tap_state == 4'hC));

  assert_shift_dr_hold_R2: assert property (@(posedge tck) disable iff (!rst_n_s)
    (tap_state == 4'h2 && !tms) |=> (tap_state == 4'h2));

  assert_reset_reload_R3: assert property (@(posedge tck) disable iff (!rst_n_s)
    (tap_state == 4'hF) |=> (path_sel == 2'b01 && test_mode == 9'h000));

  assert_strobe_exclusive_R4: assert property (@(posedge tck) disable iff (!rst_n_s)
    $onehot0({ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update}));

  assert_mode_steady_R6: assert property (@(posedge tck) disable iff (!rst_n_s)
    (tap_state != 4'hD && tap_state != 4'hF) |=> ($stable(test_mode) && $stable(path_sel)));

  assert_mode_onehot_R7: assert property (@(posedge tck) disable iff (!rst_n_s)
    $onehot0(test_mode));

  assert_internal_path_R8: assert property (@(posedge tck) disable iff (!rst_n_s)
    (path_sel == 2'b11) |-> (test_mode == 9'h004));

  assert_tdo_enable_R11: assert property (@(posedge tck) disable iff (!rst_n_s)
    tdo_en == (tap_state == 4'h2 || tap_state == 4'hA));

endmodule

bind tap_mode_ctrl tap_mode_ctrl_chk u_chk (
  .tck        (tck),
  .rst_n_s    (rst_n_s),
  .tms        (tms),
  .tap_state  (tap_state),
  .ir_capture (ir_capture),
  .ir_shift   (ir_shift),
  .ir_update  (ir_update),
  .dr_capture (dr_capture),
  .dr_shift   (dr_shift),
  .dr_update  (dr_update),
  .path_sel   (path_sel),
  .test_mode  (test_mode),
  .tdo_en     (tdo_en)
);

// File: tb/tap_mode_ctrl_test.sv
`timescale 1ns/1ps
module tap_mode_ctrl_test;

  localparam logic [31:0] EXP_ID = 32'h2B9D_6A13;

  logic       tck = 1'b0;
  logic       trst_n, tms, tdi;
  logic       bnd_so, int_so;
  logic       tdo, tdo_en;
  logic [3:0] tap_state;
  logic       ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update;
  logic [1:0] path_sel;
  logic [8:0] test_mode;

  int n_run  = 0;
  int n_fail = 0;
  bit         exp_q[$];
  string      req_q[$];

  assign bnd_so = 1'b1;
  assign int_so = 1'b0;

  always #2.5 tck = ~tck;

  tap_mode_ctrl #(.ID_W(32), .ID_VALUE(EXP_ID)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .bnd_so(bnd_so), .int_so(int_so), .tdo(tdo), .tdo_en(tdo_en),
    .tap_state(tap_state), .ir_capture(ir_capture), .ir_shift(ir_shift),
    .ir_update(ir_update), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .path_sel(path_sel), .test_mode(test_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit b, input string req);
    exp_q.push_back(b);
    req_q.push_back(req);
  endtask

  // Scoreboard monitor: each falling edge with tdo_en high consumes one item.
  initial begin
    forever begin
      @(negedge tck);
      #1;
      if (tdo_en === 1'b1) begin
        if (exp_q.size() == 0) begin
          check("R11", "unexpected shift cycle", 32'(tdo_en), 32'h0);
        end else begin
          bit    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, "tdo bit", 32'(tdo), 32'(e));
        end
      end
    end
  end

  function automatic logic [8:0] exp_mode(input logic [3:0] op);
    case (op)
      4'b0000: return 9'h001;
      4'b0001: return 9'h002;
      4'b0010: return 9'h004;
      4'b0011: return 9'h008;
      4'b0100: return 9'h010;
      4'b0111: return 9'h020;
      4'b1000: return 9'h040;
      4'b1001: return 9'h080;
      4'b1101: return 9'h100;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [1:0] exp_path(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b0111, 4'b1000, 4'b1001: return 2'b10;
      4'b0010: return 2'b11;
      4'b1110: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [5:0] exp_strobes(input logic [3:0] st);
    case (st)
      4'hE:    return 6'b100000;
      4'hA:    return 6'b010000;
      4'hD:    return 6'b001000;
      4'h6:    return 6'b000100;
      4'h2:    return 6'b000010;
      4'h5:    return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic tick(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  // From Run-Test/Idle into Shift-IR, shift four bits, stop in Exit1-IR.
  task automatic shift_ir(input logic [3:0] op);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) push(1'b0, "R5");
    for (int i = 0; i < 4; i++) tick(i == 3, op[i]);
  endtask

  task automatic load_ir(input logic [3:0] op);
    shift_ir(op);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle through n shift cycles back to Run-Test/Idle.
  task automatic shift_dr(input int n, input logic [63:0] din);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  localparam logic       W_TMS [17] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
                                        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [3:0] W_ST  [17] = '{4'hC, 4'h7, 4'h6, 4'h2, 4'h1, 4'h3, 4'h0, 4'h5,
                                        4'h7, 4'h4, 4'hE, 4'hA, 4'h9, 4'hB, 4'h8, 4'hD, 4'hC};

  initial begin
    trst_n = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b0;
    repeat (3) @(posedge tck);
    #1;
    // R1: reset state
    check("R1", "state in reset", 32'(tap_state), 32'hF);
    check("R1", "mode in reset", 32'(test_mode), 32'h0);
    check("R1", "path in reset", 32'(path_sel), 32'h1);
    check("R1", "tdo_en in reset", 32'(tdo_en), 32'h0);

    @(negedge tck);
    #1;
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    check("R3", "tms high holds reset state", 32'(tap_state), 32'hF);

    // R2 / R4: walk every state; shift cycles emit id bit0 and a captured zero.
    push(EXP_ID[0], "R10");
    push(1'b0, "R5");
    for (int i = 0; i < 17; i++) begin
      tick(W_TMS[i], 1'b0);
      check("R2", "walk state code", 32'(tap_state), 32'(W_ST[i]));
      check("R4", "walk strobes",
            32'({ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update}),
            32'(exp_strobes(W_ST[i])));
    end
    // The walk shifted 0000 into the IR: EXTEST now active.
    check("R7", "mode after walk", 32'(test_mode), 32'h001);
    check("R8", "path after walk", 32'(path_sel), 32'h2);
    check("R11", "tdo_en in idle", 32'(tdo_en), 32'h0);

    // R8: boundary path returns the chain output.
    for (int i = 0; i < 3; i++) push(1'b1, "R8");
    shift_dr(3, 64'h0);

    // R3: from Shift-DR, five tms-high edges reach reset and reload the ID opcode.
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    push(1'b1, "R8");
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    check("R3", "five tms high reach reset", 32'(tap_state), 32'hF);
    tick(1'b0, 1'b0);
    check("R3", "path reloaded", 32'(path_sel), 32'h1);
    check("R3", "mode cleared", 32'(test_mode), 32'h0);

    // R10: identification register shifts out LSB first.
    for (int i = 0; i < 32; i++) push(EXP_ID[i], "R10");
    shift_dr(32, 64'h0);

    // R9: bypass delay of one stage.
    load_ir(4'b1111);
    check("R8", "bypass path", 32'(path_sel), 32'h0);
    begin
      logic [5:0] pat;
      pat = 6'b101101;
      push(1'b0, "R9");
      for (int i = 0; i < 5; i++) push(pat[i], "R9");
      shift_dr(6, 64'(pat));
    end

    // R6: new opcode stays invisible until the update edge.
    shift_ir(4'b0011);
    check("R6", "mode held in Exit1-IR", 32'(test_mode), 32'h0);
    tick(1'b1, 1'b0);
    check("R6", "state is Update-IR", 32'(tap_state), 32'hD);
    check("R6", "mode held in Update-IR", 32'(test_mode), 32'h0);
    tick(1'b0, 1'b0);
    check("R6", "mode after update", 32'(test_mode), 32'h008);
    check("R8", "TBLK2 path is bypass", 32'(path_sel), 32'h0);

    // R8: internal chain path with tdi high gives the chain's zeros.
    load_ir(4'b0010);
    check("R8", "internal path", 32'(path_sel), 32'h3);
    for (int i = 0; i < 3; i++) push(1'b0, "R8");
    shift_dr(3, 64'hFF);

    // R7 / R8: every opcode.
    for (int op = 0; op < 16; op++) begin
      load_ir(4'(op));
      check("R7", $sformatf("mode of op %0d", op), 32'(test_mode), 32'(exp_mode(4'(op))));
      check("R8", $sformatf("path of op %0d", op), 32'(path_sel), 32'(exp_path(4'(op))));
    end

    // R1: asynchronous reset in the middle of a sequence.
    load_ir(4'b0001);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge tck);
    #1.5;
    trst_n = 1'b0;
    #0.5;
    check("R1", "async reset state", 32'(tap_state), 32'hF);
    check("R1", "async reset path", 32'(path_sel), 32'h1);
    check("R1", "async reset mode", 32'(test_mode), 32'h0);
    repeat (2) @(posedge tck);
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check("R2", "idle after reset", 32'(tap_state), 32'hC);
    repeat (2) @(posedge tck);
    #1;
    check("R11", "tdo_en low outside shift", 32'(tdo_en), 32'h0);
    check("R11", "no pending shift items", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule